// File: doc/BRIEF.md
# Interrupter Runtime Register and Signalling Unit

This block holds the runtime register set of one host-controller interrupter and drives that interrupter's outgoing interrupt signals. Software reaches the registers through a simple 32-bit register port: one write strobe, a byte offset and write data. Read data is returned combinationally for whichever offset is currently presented. Two flags, interrupt-pending and event-handler-busy, are cleared only by writing a 1 to them. Every other field either takes the written value or is masked as it is stored.

The event logic elsewhere in the controller pulses `evt_raise` when it has placed an event on the ring. The unit then sets pending, busy and a global event-interrupt status bit. If the interrupter's enable bit is set, it notifies the host through one of three paths, in this order of preference: a message-table pulse, a plain message pulse, or a level line. Only interrupter number 0 may drive the level line. Writes to two particular high words produce one-cycle strobes: one asks the segment logic to reload the event-ring segment, and the other asks the event logic to drain events it has queued.

Top module: `irq_rt_top`

## Requirements
- R1: Registers sit at these byte offsets: 0x24 interrupt moderation (32 bits, read back as written), 0x34 segment-table base high word (32 bits), and 0x3C dequeue-pointer high word (32 bits). Read data reflects the register state at the offset currently presented.
- R2: Offset 0x20 is the interrupter control register: bit 0 is pending and bit 1 is enable, and all other bits read 0. Writing a 1 to bit 0 clears pending, while writing a 0 leaves it unchanged. Enable always takes bit 1 of the written value.
- R3: Offset 0x28 (segment count) keeps only the low 16 bits of a write. Offset 0x30 (segment-table base low word) is stored with bits 3:0 forced to 0.
- R4: At offset 0x38 (dequeue-pointer low word), every bit except bit 3 takes the written value. Bit 3 is the busy flag: it is cleared by writing 1 and kept when written as 0.
- R5: A raise sets pending, busy and the sticky `evt_int_sts` output one cycle later. If a raise arrives in the same cycle as a write-1 clear of pending or busy, the raise wins and the flag ends up set.
- R6: A raise that finds enable set (its value after any same-cycle write) produces a one-cycle pulse on the next cycle. The pulse goes on `msix_fire` if `msix_on` is high, otherwise on `msi_fire` if `msi_on` is high. If enable is clear, no pulse goes out.
- R7: For interrupter index 0, `legacy_irq` is reloaded on every write to 0x20, and on every raise that finds enable set. It loads pending AND enable AND `cmd_irq_en` AND neither message mode on. In every other cycle it holds its value. For a nonzero index, `legacy_irq` stays 0.
- R8: On a write to 0x20 while `msix_on` is high, `vec_in_use` takes the written enable bit. At all other times it keeps its value.
- R9: A write to 0x34 pulses `seg_reload` for one cycle on the next cycle. A write to 0x3C does the same for `evt_drain`.
- R10: Reads from any offset not listed above return 0. Writes to such an offset change no register and no output.
- R11: While reset is active, all registers, `evt_int_sts`, `vec_in_use`, `legacy_irq` and every strobe read or drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_raise | input | 1 | Raise request from the event logic |
| cmd_irq_en | input | 1 | Global interrupter enable from the command register |
| msix_on | input | 1 | Message-table interrupts enabled |
| msi_on | input | 1 | Plain message interrupts enabled |
| legacy_irq | output | 1 | Level interrupt line |
| msix_fire | output | 1 | Message-table notification pulse |
| msi_fire | output | 1 | Plain message notification pulse |
| vec_in_use | output | 1 | Message vector claimed by this interrupter |
| evt_int_sts | output | 1 | Sticky global event-interrupt status |
| seg_reload | output | 1 | Segment reload request strobe |
| evt_drain | output | 1 | Queued-event drain request strobe |

## Verification
The hardest situation to bring about is a raise that lands in the same cycle as a write-1 clear of pending or busy. A second such case is a write that changes the enable bit in the cycle of a raise, which decides whether any notification leaves at all. A directed step places the raise exactly on an enable write and on a pending clear. Long random runs with frequent raises and writes, with the three mode inputs toggling, then reach every combination many times. A second instance with a nonzero index runs on the same stimulus, to show that the level line stays silent there.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

  localparam int REG_W = 32;

  // byte offsets decoded by neighbouring software-visible logic
  localparam int OFS_CTRL   = 'h20;
  localparam int OFS_MODER  = 'h24;
  localparam int OFS_SEGCNT = 'h28;
  localparam int OFS_SEGLO  = 'h30;
  localparam int OFS_SEGHI  = 'h34;
  localparam int OFS_DQLO   = 'h38;
  localparam int OFS_DQHI   = 'h3C;

  // bit positions inside the control and dequeue-low words
  localparam int PEND_BIT = 0;
  localparam int ENA_BIT  = 1;
  localparam int BUSY_BIT = 3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_MODER, SEL_SEGCNT,
    SEL_SEGLO, SEL_SEGHI, SEL_DQLO, SEL_DQHI
  } reg_sel_e;

  typedef struct packed {
    logic ctrl;
    logic moder;
    logic segcnt;
    logic seglo;
    logic seghi;
    logic dqlo;
    logic dqhi;
  } wr_strb_t;

endpackage

// File: rtl/irq_rt_rstsync.sv
module irq_rt_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_rt_decode.sv
module irq_rt_decode
  import irq_rt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output wr_strb_t          strb
);

  always_comb begin
    case (addr)
      ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
      ADDR_W'(OFS_MODER):  sel = SEL_MODER;
      ADDR_W'(OFS_SEGCNT): sel = SEL_SEGCNT;
      ADDR_W'(OFS_SEGLO):  sel = SEL_SEGLO;
      ADDR_W'(OFS_SEGHI):  sel = SEL_SEGHI;
      ADDR_W'(OFS_DQLO):   sel = SEL_DQLO;
      ADDR_W'(OFS_DQHI):   sel = SEL_DQHI;
      default:             sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb = '0;
    if (wr) begin
      case (sel)
        SEL_CTRL:   strb.ctrl   = 1'b1;
        SEL_MODER:  strb.moder  = 1'b1;
        SEL_SEGCNT: strb.segcnt = 1'b1;
        SEL_SEGLO:  strb.seglo  = 1'b1;
        SEL_SEGHI:  strb.seghi  = 1'b1;
        SEL_DQLO:   strb.dqlo   = 1'b1;
        SEL_DQHI:   strb.dqhi   = 1'b1;
        default:    strb        = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int SZ_W    = 16,
  parameter int ALIGN_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  wr_strb_t         strb,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             raise,
  output logic [REG_W-1:0] rdata,
  output logic             pend_d,
  output logic             ena_d,
  output logic             evt_sts,
  output logic             reload_req,
  output logic             drain_req
);
  localparam int PAD_W = REG_W - SZ_W;

  logic [1:0]             ctrl_q, ctrl_d;
  logic                   ctrl_en;
  logic [REG_W-1:0]       moder_q;
  logic [SZ_W-1:0]        segcnt_q;
  logic [REG_W-1:ALIGN_W] seglo_q;
  logic [REG_W-1:0]       seghi_q;
  logic [REG_W-1:0]       dqlo_q, dqlo_d;
  logic                   dqlo_en;
  logic [REG_W-1:0]       dqhi_q;
  logic                   sts_q;
  logic                   reload_q, drain_q;

  // next state of the two words that carry clear-by-one flags
  always_comb begin
    ctrl_d = ctrl_q;
    if (strb.ctrl) begin
      if (wdata[PEND_BIT]) ctrl_d[PEND_BIT] = 1'b0;
      ctrl_d[ENA_BIT] = wdata[ENA_BIT];
    end
    if (raise) ctrl_d[PEND_BIT] = 1'b1;
    ctrl_en = strb.ctrl | raise;

    dqlo_d = dqlo_q;
    if (strb.dqlo) begin
      dqlo_d           = wdata;
      dqlo_d[BUSY_BIT] = dqlo_q[BUSY_BIT] & ~wdata[BUSY_BIT];
    end
    if (raise) dqlo_d[BUSY_BIT] = 1'b1;
    dqlo_en = strb.dqlo | raise;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      moder_q  <= '0;
      segcnt_q <= '0;
      seglo_q  <= '0;
      seghi_q  <= '0;
      dqlo_q   <= '0;
      dqhi_q   <= '0;
      sts_q    <= 1'b0;
      reload_q <= 1'b0;
      drain_q  <= 1'b0;
    end else begin
      if (ctrl_en)     ctrl_q   <= ctrl_d;
      if (strb.moder)  moder_q  <= wdata;
      if (strb.segcnt) segcnt_q <= wdata[SZ_W-1:0];
      if (strb.seglo)  seglo_q  <= wdata[REG_W-1:ALIGN_W];
      if (strb.seghi)  seghi_q  <= wdata;
      if (dqlo_en)     dqlo_q   <= dqlo_d;
      if (strb.dqhi)   dqhi_q   <= wdata;
      if (raise)       sts_q    <= 1'b1;
      reload_q <= strb.seghi;
      drain_q  <= strb.dqhi;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:   rdata = {{(REG_W-2){1'b0}}, ctrl_q};
      SEL_MODER:  rdata = moder_q;
      SEL_SEGCNT: rdata = {{PAD_W{1'b0}}, segcnt_q};
      SEL_SEGLO:  rdata = {seglo_q, {ALIGN_W{1'b0}}};
      SEL_SEGHI:  rdata = seghi_q;
      SEL_DQLO:   rdata = dqlo_q;
      SEL_DQHI:   rdata = dqhi_q;
      default:    rdata = '0;
    endcase
  end

  assign pend_d     = ctrl_d[PEND_BIT];
  assign ena_d      = ctrl_d[ENA_BIT];
  assign evt_sts    = sts_q;
  assign reload_req = reload_q;
  assign drain_req  = drain_q;

  // R5: a raise leaves pending, busy and the status bit set
  p_raise_sets_flags_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    raise |=> (ctrl_q[PEND_BIT] && dqlo_q[BUSY_BIT] && sts_q));

  // R4: writing busy as 0 keeps it
  p_busy_kept_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (strb.dqlo && !wdata[BUSY_BIT] && !raise) |=> $stable(dqlo_q[BUSY_BIT]));

  // R2: writing pending as 1 clears it when no raise competes
  p_pend_clear_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (strb.ctrl && wdata[PEND_BIT] && !raise) |=> !ctrl_q[PEND_BIT]);

  // R9: the high-word writes produce their strobes on the next cycle
  p_reload_strobe_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    strb.seghi |=> reload_q);
  p_drain_strobe_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    strb.dqhi |=> drain_q);

endmodule

// File: rtl/irq_rt_notify.sv
module irq_rt_notify #(
  parameter int INTR_INDEX = 0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic raise,
  input  logic ctrl_wr,
  input  logic pend_d,
  input  logic ena_d,
  input  logic msix_on,
  input  logic msi_on,
  input  logic cmd_irq_en,
  output logic legacy_irq,
  output logic msix_fire,
  output logic msi_fire,
  output logic vec_in_use
);
  localparam bit LEGACY_OK = (INTR_INDEX == 0);

  logic fire_x_d, fire_m_d, fire_x_q, fire_m_q;
  logic vec_en, vec_q;

  // routing preference: message table, then plain message
  always_comb begin
    fire_x_d = raise & ena_d & msix_on;
    fire_m_d = raise & ena_d & ~msix_on & msi_on;
    vec_en   = ctrl_wr & msix_on;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_x_q <= 1'b0;
      fire_m_q <= 1'b0;
      vec_q    <= 1'b0;
    end else begin
      fire_x_q <= fire_x_d;
      fire_m_q <= fire_m_d;
      if (vec_en) vec_q <= ena_d;
    end
  end

  assign msix_fire  = fire_x_q;
  assign msi_fire   = fire_m_q;
  assign vec_in_use = vec_q;

  generate
    if (LEGACY_OK) begin : g_legacy
      logic leg_en, leg_d, leg_q;

      always_comb begin
        leg_en = ctrl_wr | (raise & ena_d);
        leg_d  = pend_d & ena_d & cmd_irq_en & ~msix_on & ~msi_on;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)     leg_q <= 1'b0;
        else if (leg_en) leg_q <= leg_d;
      end

      assign legacy_irq = leg_q;

      // R7: a control write that leaves pending clear drops the line
      p_legacy_drop_r7: assert property (@(posedge clk) disable iff (!rst_ni)
        (ctrl_wr && !pend_d) |=> !legacy_irq);

      // R7: the line holds while neither a control write nor an enabled raise occurs
      p_legacy_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
        (!ctrl_wr && !(raise && ena_d)) |=> $stable(legacy_irq));
    end else begin : g_no_legacy
      assign legacy_irq = 1'b0;
    end
  endgenerate

  // R6: an enabled raise with the table mode on pulses only that path
  p_route_table_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (raise && ena_d && msix_on) |=> (msix_fire && !msi_fire));

  // R6: no pulse without an enabled raise
  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!raise || !ena_d) |=> (!msix_fire && !msi_fire));

  // R8: vector flag follows the written enable under the table mode
  p_vec_follow_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && msix_on) |=> (vec_in_use == $past(ena_d)));

endmodule

// File: rtl/irq_rt_top.sv
module irq_rt_top
  import irq_rt_pkg::*;
#(
  parameter int INTR_INDEX = 0,
  parameter int ADDR_W     = 8,
  parameter int SZ_W       = 16,
  parameter int ALIGN_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              evt_raise,
  input  logic              cmd_irq_en,
  input  logic              msix_on,
  input  logic              msi_on,
  output logic              legacy_irq,
  output logic              msix_fire,
  output logic              msi_fire,
  output logic              vec_in_use,
  output logic              evt_int_sts,
  output logic              seg_reload,
  output logic              evt_drain
);
  logic     rst_sync_n;
  reg_sel_e sel;
  wr_strb_t strb;
  logic     pend_d, ena_d;

  irq_rt_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_rt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (reg_addr),
    .wr   (reg_wr),
    .sel  (sel),
    .strb (strb)
  );

  irq_rt_regs #(.SZ_W(SZ_W), .ALIGN_W(ALIGN_W)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .strb       (strb),
    .sel        (sel),
    .wdata      (reg_wdata),
    .raise      (evt_raise),
    .rdata      (reg_rdata),
    .pend_d     (pend_d),
    .ena_d      (ena_d),
    .evt_sts    (evt_int_sts),
    .reload_req (seg_reload),
    .drain_req  (evt_drain)
  );

  irq_rt_notify #(.INTR_INDEX(INTR_INDEX)) u_notify (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .raise      (evt_raise),
    .ctrl_wr    (strb.ctrl),
    .pend_d     (pend_d),
    .ena_d      (ena_d),
    .msix_on    (msix_on),
    .msi_on     (msi_on),
    .cmd_irq_en (cmd_irq_en),
    .legacy_irq (legacy_irq),
    .msix_fire  (msix_fire),
    .msi_fire   (msi_fire),
    .vec_in_use (vec_in_use)
  );

  // R10: a write to an unmapped offset produces no strobe on the next cycle
  p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && sel == SEL_NONE && !evt_raise) |=> (!seg_reload && !evt_drain));

endmodule

// File: tb/irq_rt_top_tb_top.sv
`timescale 1ns/1ps
module irq_rt_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        evt_raise, cmd_irq_en, msix_on, msi_on;

  logic [31:0] rd0, rd1;
  logic leg0, fx0, fm0, vec0, sts0, rl0, dr0;
  logic leg1, fx1, fm1, vec1, sts1, rl1, dr1;

  always #10 clk = ~clk;

  irq_rt_top #(.INTR_INDEX(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd0), .evt_raise(evt_raise),
    .cmd_irq_en(cmd_irq_en), .msix_on(msix_on), .msi_on(msi_on),
    .legacy_irq(leg0), .msix_fire(fx0), .msi_fire(fm0), .vec_in_use(vec0),
    .evt_int_sts(sts0), .seg_reload(rl0), .evt_drain(dr0));

  irq_rt_top #(.INTR_INDEX(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd1), .evt_raise(evt_raise),
    .cmd_irq_en(cmd_irq_en), .msix_on(msix_on), .msi_on(msi_on),
    .legacy_irq(leg1), .msix_fire(fx1), .msi_fire(fm1), .vec_in_use(vec1),
    .evt_int_sts(sts1), .seg_reload(rl1), .evt_drain(dr1));

  // behavioural reference state
  bit [1:0]  m_ctrl = 0;
  bit [31:0] m_moder = 0, m_cnt = 0, m_blo = 0, m_bhi = 0, m_dlo = 0, m_dhi = 0;
  bit m_sts = 0, m_leg = 0, m_fx = 0, m_fm = 0, m_vec = 0, m_rl = 0, m_dr = 0;

  int  n_chk = 0, n_bad = 0;
  bit  in_rst = 1;
  bit  done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_moder = 0; m_cnt = 0; m_blo = 0; m_bhi = 0; m_dlo = 0; m_dhi = 0;
      m_sts = 0; m_leg = 0; m_fx = 0; m_fm = 0; m_vec = 0; m_rl = 0; m_dr = 0;
    end else begin
      bit ctrl_w;
      ctrl_w = reg_wr && reg_addr == 8'h20;
      if (reg_wr) begin
        case (reg_addr)
          8'h20: begin if (reg_wdata[0]) m_ctrl[0] = 0; m_ctrl[1] = reg_wdata[1]; end
          8'h24: m_moder = reg_wdata;
          8'h28: m_cnt = reg_wdata & 32'h0000_FFFF;
          8'h30: m_blo = reg_wdata & 32'hFFFF_FFF0;
          8'h34: m_bhi = reg_wdata;
          8'h38: m_dlo = (reg_wdata & ~32'h8) | ((reg_wdata[3] ? 32'h0 : m_dlo) & 32'h8);
          8'h3C: m_dhi = reg_wdata;
          default: ;
        endcase
      end
      if (evt_raise) begin m_ctrl[0] = 1; m_dlo[3] = 1; m_sts = 1; end
      m_fx = evt_raise && m_ctrl[1] && msix_on;
      m_fm = evt_raise && m_ctrl[1] && !msix_on && msi_on;
      if (ctrl_w || (evt_raise && m_ctrl[1]))
        m_leg = m_ctrl[0] && m_ctrl[1] && cmd_irq_en && !msix_on && !msi_on;
      if (ctrl_w && msix_on) m_vec = m_ctrl[1];
      m_rl = reg_wr && reg_addr == 8'h34;
      m_dr = reg_wr && reg_addr == 8'h3C;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h20: return {30'd0, m_ctrl};
      8'h24: return m_moder;
      8'h28: return m_cnt;
      8'h30: return m_blo;
      8'h34: return m_bhi;
      8'h38: return m_dlo;
      8'h3C: return m_dhi;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h20: return "R2";
      8'h24, 8'h34, 8'h3C: return "R1";
      8'h28, 8'h30: return "R3";
      8'h38: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%08h expected=%08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t5, t6, t7, t8, t9;
    t5 = in_rst ? "R11" : "R5";
    t6 = in_rst ? "R11" : "R6";
    t7 = in_rst ? "R11" : "R7";
    t8 = in_rst ? "R11" : "R8";
    t9 = in_rst ? "R11" : "R9";
    chk(in_rst ? "R11" : tag_of(reg_addr), "rdata idx0", rd0, m_read(reg_addr));
    chk(in_rst ? "R11" : tag_of(reg_addr), "rdata idx1", rd1, m_read(reg_addr));
    chk(t7, "legacy_irq idx0", 32'(leg0), 32'(m_leg));
    chk(t6, "legacy_irq idx1 stays low", 32'(leg1), 32'd0);
    chk(t6, "msix_fire", 32'({fx1, fx0}), 32'({m_fx, m_fx}));
    chk(t6, "msi_fire", 32'({fm1, fm0}), 32'({m_fm, m_fm}));
    chk(t8, "vec_in_use", 32'({vec1, vec0}), 32'({m_vec, m_vec}));
    chk(t5, "evt_int_sts", 32'({sts1, sts0}), 32'({m_sts, m_sts}));
    chk(t9, "seg_reload", 32'({rl1, rl0}), 32'({m_rl, m_rl}));
    chk(t9, "evt_drain", 32'({dr1, dr0}), 32'({m_dr, m_dr}));
  endtask

  task automatic step(bit wr, logic [7:0] a, logic [31:0] d, bit rs);
    @(negedge clk);
    compare();
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_raise = rs;
  endtask

  task automatic read_all();
    logic [7:0] offs [9] = '{8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h2C, 8'h00};
    for (int i = 0; i < 9; i++) step(0, offs[i], 32'd0, 0);
  endtask

  initial begin
    logic [7:0] pool [11] = '{8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38, 8'h3C,
                              8'h2C, 8'h00, 8'h40, 8'hFF};
    rst_n = 0; reg_wr = 0; reg_addr = 8'h20; reg_wdata = 0; evt_raise = 0;
    cmd_irq_en = 0; msix_on = 0; msi_on = 0;
    // R11: reset state while reset is held, then during synchronous release
    repeat (3) step(0, 8'h20, 32'd0, 0);
    rst_n = 1;
    repeat (4) step(0, 8'h38, 32'd0, 0);
    in_rst = 0;

    // R2/R7: enable, raise on the level line, then clear pending by writing 1
    cmd_irq_en = 1;
    step(1, 8'h20, 32'h2, 0);
    step(0, 8'h20, 32'd0, 1);
    step(0, 8'h20, 32'd0, 0);
    step(1, 8'h20, 32'h3, 0);
    step(0, 8'h20, 32'd0, 0);
    // R6/R8: table mode claims the vector and pulses
    msix_on = 1;
    step(1, 8'h20, 32'h2, 0);
    step(0, 8'h20, 32'd0, 1);
    step(0, 8'h20, 32'd0, 0);
    msix_on = 0; msi_on = 1;
    step(0, 8'h20, 32'd0, 1);
    step(0, 8'h20, 32'd0, 0);
    msi_on = 0;
    // R6: raise with enable cleared in the same cycle sends nothing
    step(1, 8'h20, 32'h1, 1);
    step(0, 8'h20, 32'd0, 0);
    // R5: raise beats a same-cycle write-1 clear of pending
    step(1, 8'h20, 32'h3, 1);
    step(0, 8'h20, 32'd0, 0);
    // R3/R1/R9: masking and strobes
    step(1, 8'h28, 32'hABCD_1234, 0);
    step(1, 8'h30, 32'hFFFF_FFFF, 0);
    step(1, 8'h34, 32'h1357_9BDF, 0);
    step(1, 8'h24, 32'hDEAD_BEEF, 0);
    step(1, 8'h3C, 32'h0000_00A5, 0);
    read_all();
    // R4: busy handling in the dequeue low word
    step(1, 8'h38, 32'h1234_5678, 0);
    step(0, 8'h38, 32'd0, 1);
    step(1, 8'h38, 32'h0000_0000, 0);
    step(0, 8'h38, 32'd0, 0);
    step(1, 8'h38, 32'hFFFF_FFF8, 1);
    step(0, 8'h38, 32'd0, 0);
    step(1, 8'h38, 32'h0000_0008, 0);
    step(0, 8'h38, 32'd0, 0);
    // R10: unmapped writes change nothing visible
    step(1, 8'h2C, 32'hFFFF_FFFF, 0);
    step(1, 8'h40, 32'hFFFF_FFFF, 0);
    step(1, 8'h00, 32'hFFFF_FFFF, 0);
    read_all();

    // random phase covering all requirements
    for (int n = 0; n < 6000; n++) begin
      bit wr, rs;
      logic [31:0] d;
      wr = ($urandom_range(0, 9) < 4);
      rs = ($urandom_range(0, 9) < 2);
      d  = $urandom;
      if ($urandom_range(0, 3) == 0) d[3:0] = 4'($urandom_range(0, 15));
      step(wr, pool[$urandom_range(0, 10)], d, rs);
      if ($urandom_range(0, 40) == 0) msix_on = ~msix_on;
      if ($urandom_range(0, 40) == 0) msi_on = ~msi_on;
      if ($urandom_range(0, 40) == 0) cmd_irq_en = ~cmd_irq_en;
    end
    step(0, 8'h20, 32'd0, 0);
    step(0, 8'h20, 32'd0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule